// File: doc/BRIEF.md
# Handshaked Serial Byte Transmitter

This block takes one 8-bit character at a time from a producer and sends it out on a single serial wire. The producer puts a byte on the data bus and raises a request. The block takes the byte on the clock edge where it raises its acknowledge. It then drives a frame onto the line. The frame is one low start bit, then the eight data bits with the most significant bit first, then a high stop bit. Each bit lasts a fixed number of clock cycles, and that number is set by a parameter.

The transfer uses a full four-phase exchange. The producer raises the request and the block answers with the acknowledge. The producer then drops the request, and the block drops the acknowledge. The block drops the acknowledge only when both of these are true: the whole frame, stop bit included, has left the wire, and the request is low. Either side may wait as long as it likes before any of its edges. While the acknowledge is high, the block starts no new frame. The line sits high whenever no frame is running.

Top module: `hs_serial_tx`

## Requirements
- R1: The serial line is high whenever no frame is in progress, including all time after reset until the first request and between frames.
- R2: A frame begins on the clock edge where the acknowledge rises: from that edge the line is low for the start bit.
- R3: After the start bit the eight data bits appear in order from bit 7 down to bit 0, a 1 driven as line high.
- R4: The start bit, every data bit and the stop bit each hold the line for exactly CLKS_PER_BIT clock cycles.
- R5: After bit 0 the line is high for at least CLKS_PER_BIT cycles before any following start bit.
- R6: When idle with the acknowledge low, a request seen high at a clock edge raises the acknowledge at that same edge.
- R7: The byte sent is the data bus value at the edge where the acknowledge rises; later changes on the bus do not alter the frame.
- R8: The acknowledge stays high until the frame has ended and the request is low. It falls at the first clock edge at which both hold, which is one cycle after the later of the two events.
- R9: A request held high past the end of a frame starts no second frame: the line stays high and the acknowledge stays high until the request drops.
- R10: Synchronous active-high reset drives the line high and the acknowledge low, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Producer request, raised with a byte on send_data |
| send_data | input | 8 | Byte to send; sampled when ack_out rises |
| ack_out | output | 1 | Four-phase acknowledge to the producer |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The bench sends six bytes: 0xA5, 0x00, 0xFF, 0x80, 0x01 and 0x3C. These mix alternating bits, long low and long high runs, and a single set bit at either end of the byte. Because of this, errors in bit order, in bit length and in how the start bit or stop bit joins the data bits each give a different wrong waveform. The producer uses three styles of request. It drops the request almost at once, it drops it just as the frame ends, or it holds it well past the end. These three cases tell apart an acknowledge that falls too early, one that falls late, and one that lets a held request start a second frame. The data bus is inverted right after each acknowledge, which shows whether the byte is captured at the correct edge.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;

    localparam int WORD_W  = 8;
    localparam int FRAME_W = WORD_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_ACKED = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic   busy;
        idx_t   idx;
        frame_t sh;
    } shift_st_t;

    // Frame image with the first bit on the wire at the top: low start,
    // data from bit 7 down to bit 0, high stop.
    function automatic frame_t build_frame(input word_t w);
        return {1'b0, w, 1'b1};
    endfunction

    function automatic frame_t idle_frame();
        return '1;
    endfunction

endpackage

// File: rtl/tx_handshake.sv
module tx_handshake
    import hs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic send_req,
    input  logic frame_busy,
    output logic ack,
    output logic start
);

    hs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (send_req) state_d = HS_ACKED;
            end
            HS_ACKED: begin
                if (!send_req && !frame_busy) state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_IDLE;
        else     state_q <= state_d;
    end

    assign ack   = (state_q == HS_ACKED);
    assign start = (state_q == HS_IDLE) && send_req;

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic tick
);

    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt_q <= '0;
        else if (at_last)         cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && at_last;

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
    import hs_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_word,
    input  logic  tick,
    output logic  busy,
    output logic  tx
);

    localparam idx_t LAST_IDX = idx_t'(FRAME_W - 1);

    shift_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.sh   = build_frame(load_word);
        end else if (st_q.busy && tick) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
                st_d.sh   = idle_frame();
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.sh  = {st_q.sh[FRAME_W-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.idx  <= '0;
            st_q.sh   <= idle_frame();
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign tx   = st_q.sh[FRAME_W-1];

endmodule

// File: rtl/hs_serial_tx.sv
module hs_serial_tx
    import hs_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_req,
    input  logic [WORD_W-1:0] send_data,
    output logic              ack_out,
    output logic              tx_line
);

    logic start_pulse;
    logic bit_tick;
    logic frame_busy;

    tx_handshake u_hs (
        .clk        (clk),
        .rst        (rst),
        .send_req   (send_req),
        .frame_busy (frame_busy),
        .ack        (ack_out),
        .start      (start_pulse)
    );

    tx_bit_timer #(
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (frame_busy),
        .clear (start_pulse),
        .tick  (bit_tick)
    );

    tx_frame_shifter u_shf (
        .clk       (clk),
        .rst       (rst),
        .load      (start_pulse),
        .load_word (send_data),
        .tick      (bit_tick),
        .busy      (frame_busy),
        .tx        (tx_line)
    );

endmodule

// File: rtl/hs_serial_tx_chk.sv
module hs_serial_tx_chk #(
    parameter int CLKS_PER_BIT = 16
) (
    input logic clk,
    input logic rst,
    input logic send_req,
    input logic ack_out,
    input logic tx_line,
    input logic frame_busy
);

    logic [31:0] run_len;
    logic        prev_tx;
    logic        prev_ack;
    logic        rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            prev_tx  <= 1'b1;
            prev_ack <= 1'b0;
        end else begin
            prev_tx  <= tx_line;
            prev_ack <= ack_out;
            run_len  <= (tx_line != prev_tx) ? 32'd1 : run_len + 32'd1;
        end
    end

    // R1: no frame running means the line is high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !frame_busy |-> tx_line);

    // R2: the acknowledge edge coincides with the start bit
    a_r2_start_with_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_out) |-> !tx_line);

    // R4: inside a frame every level run is a whole number of bit times
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (ack_out && prev_ack && (tx_line != prev_tx)) |-> ((run_len % CLKS_PER_BIT) == 0));

    // R6: acknowledge rises only in answer to a request
    a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_out) |-> $past(send_req));

    // R8: acknowledge falls only after request low and frame done
    a_r8_ack_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_out) |-> (!$past(send_req) && !$past(frame_busy)));

    // R8: acknowledge covers the whole frame
    a_r8_ack_covers_frame: assert property (@(posedge clk) disable iff (rst)
        frame_busy |-> ack_out);

    // R9: no frame starts while the acknowledge is already high
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (ack_out && prev_ack && !frame_busy) |=> !frame_busy);

    // R10: one cycle after reset the outputs are at rest
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            a_r10_reset_state: assert (tx_line && !ack_out)
                else $error("reset state wrong");
        end
    end

endmodule

bind hs_serial_tx hs_serial_tx_chk #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .send_req   (send_req),
    .ack_out    (ack_out),
    .tx_line    (tx_line),
    .frame_busy (frame_busy)
);

// File: tb/hs_serial_tx_tb.sv
module hs_serial_tx_tb;
    import hs_tx_pkg::*;

    localparam int CPB       = 16;
    localparam int FRAME_CYC = FRAME_W * CPB;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  send_req = 1'b0;
    word_t send_data = '0;
    logic  ack_out;
    logic  tx_line;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    word_t exp_q[$];

    always #5 clk = ~clk;

    hs_serial_tx #(.CLKS_PER_BIT(CPB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .send_req  (send_req),
        .send_data (send_data),
        .ack_out   (ack_out),
        .tx_line   (tx_line)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: push expected byte, run one four-phase exchange, drop the
    // request 'hold' negedges after the acknowledge is first seen.
    task automatic send_byte(input word_t d, input int hold);
        int fall;
        @(negedge clk);
        exp_q.push_back(d);
        send_data = d;
        send_req  = 1'b1;
        @(negedge clk);
        chk(ack_out == 1'b1, "R6", "ack one edge after request", int'(ack_out), 1);
        chk(tx_line == 1'b0, "R2", "start bit at ack edge", int'(tx_line), 0);
        send_data = ~d;   // R7: bus changes after capture
        fall = ((hold > FRAME_CYC) ? hold : FRAME_CYC) + 1;
        for (int i = 1; i <= fall; i++) begin
            @(negedge clk);
            if (i == 3 * CPB && hold < 3 * CPB)
                chk(ack_out == 1'b1, "R8", "ack held mid-frame", int'(ack_out), 1);
            if (hold > FRAME_CYC + 1 && i == hold - 1)
                chk(tx_line == 1'b1 && ack_out == 1'b1, "R9", "held request starts nothing",
                    int'({ack_out, tx_line}), 3);
            if (i == fall - 1)
                chk(ack_out == 1'b1, "R8", "ack still high before fall", int'(ack_out), 1);
            if (i == fall)
                chk(ack_out == 1'b0, "R8", "ack fall edge", int'(ack_out), 0);
            if (i == hold) send_req = 1'b0;
        end
    endtask

    // Monitor: on each start bit pop the expected byte and compare every
    // cycle of the frame.
    initial begin
        logic  prev;
        int    hi_run;
        bit    had;
        word_t d;
        word_t rx;
        logic  eb;
        int    bad;
        prev = 1'b1;
        hi_run = 0;
        had = 1'b0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (prev && !tx_line) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected start bit", 0, 1);
                    d = '0;
                end else begin
                    d = exp_q.pop_front();
                end
                if (had) chk(hi_run >= CPB, "R5", "high time before start", hi_run, CPB);
                rx = '0;
                for (int k = 0; k < FRAME_W; k++) begin
                    if (k == 0)                eb = 1'b0;
                    else if (k == FRAME_W - 1) eb = 1'b1;
                    else                       eb = d[WORD_W - k];
                    bad = 0;
                    for (int c = 0; c < CPB; c++) begin
                        if (!(k == 0 && c == 0)) @(negedge clk);
                        if (tx_line !== eb) bad++;
                        if (c == CPB / 2 && k > 0 && k < FRAME_W - 1) rx[WORD_W - k] = tx_line;
                    end
                    if (k == 0)
                        chk(bad == 0, "R2 R4", "start bit cycles wrong", bad, 0);
                    else if (k == FRAME_W - 1)
                        chk(bad == 0, "R5 R4", "stop bit cycles wrong", bad, 0);
                    else
                        chk(bad == 0, "R3 R4", $sformatf("data bit %0d cycles wrong", WORD_W - k), bad, 0);
                end
                chk(rx == d, "R7", "received byte", int'(rx), int'(d));
                hi_run = CPB;
                had = 1'b1;
                prev = 1'b1;
            end else begin
                hi_run = tx_line ? hi_run + 1 : 0;
                prev = tx_line;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(tx_line == 1'b1, "R10", "line in reset", int'(tx_line), 1);
        chk(ack_out == 1'b0, "R10", "ack in reset", int'(ack_out), 0);
        rst = 1'b0;
        repeat (CPB + 4) @(negedge clk);
        chk(tx_line == 1'b1, "R1", "idle line after reset", int'(tx_line), 1);
        chk(ack_out == 1'b0, "R1", "idle ack after reset", int'(ack_out), 0);

        send_byte(8'hA5, 2);
        send_byte(8'h00, FRAME_CYC);
        send_byte(8'hFF, FRAME_CYC + 3 * CPB);
        send_byte(8'h80, 1);
        send_byte(8'h01, 5 * CPB);
        send_byte(8'h3C, 2);

        repeat (2 * CPB) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all frames observed", exp_q.size(), 0);
        chk(tx_line == 1'b1, "R1", "line high after last frame", int'(tx_line), 1);
        report();
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 run did not end actual=%0d expected=%0d", 1, 0);
        report();
    end

endmodule